// File: doc/BRIEF.md
# SDRAM Data I/O Mask and Clock-Suspend Pipeline

This block sits at the device side of a synchronous DRAM data port, between the array read/write paths and the DQ pad drivers. Read beats from the array pass through a short output pipeline that ends in the pad output enable. Each beat carries the data-mask input sampled in the same cycle, so a mask on a read turns the drivers off two clocks later. A mask on a write blocks that write strobe in the same cycle.

The clock-enable input is registered once. Its registered value gates every pipeline stage and the write strobe. A low clock enable therefore freezes the read pipeline and stretches the burst, one clock after the low level is sampled, and it releases one clock after the high level returns. Command decode, address generation and the array are outside this block.

Top module: `sdram_dio_ctrl`

## Requirements
- R1: During and right after reset, `dq_oe_o` and `wr_en_o` are 0 and `rd_data_o` is all zeros.
- R2: A beat with `rd_valid_i`=1 and `dqm_i`=0, sampled at an enabled edge, appears on `rd_data_o` with `dq_oe_o`=1 after the second enabled edge. The first of those two edges is the one that samples it.
- R3: A read beat sampled with `dqm_i`=1 is delivered with `dq_oe_o`=0, so the mask takes effect two clocks after it is sampled.
- R4: `wr_en_o` is 1 exactly when `wr_valid_i`=1, `dqm_i`=0 and the clock is enabled, in the same cycle and with no register in the path.
- R5: The clock is enabled at an edge when `cke_i` was 1 at the previous edge. After reset the clock counts as enabled.
- R6: At an edge where the clock is not enabled, `rd_data_o` and `dq_oe_o` keep their values.
- R7: While the clock is not enabled, `wr_en_o` stays 0 whatever `wr_valid_i` and `dqm_i` are.
- R8: `dq_oe_o` is 0 whenever the output stage holds no valid read beat.
- R9: If a read burst is cut short by a write, and `dqm_i` is high from two cycles before the first write, then `dq_oe_o` and `wr_en_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low requests suspend |
| dqm_i | input | 1 | Data mask for read output and write strobe |
| rd_valid_i | input | 1 | Read beat from array valid this cycle |
| rd_data_i | input | DQ_W | Read beat data from array |
| wr_valid_i | input | 1 | Write beat on the bus this cycle |
| rd_data_o | output | DQ_W | Read data towards pad drivers |
| dq_oe_o | output | 1 | Pad output enable |
| wr_en_o | output | 1 | Per-cycle write strobe to array |

## Verification
The bench aims at the unequal mask latencies. A design that put the read mask one stage early or late would blank the wrong beat, and a write strobe passed through a register would let a masked write through one cycle late. It suspends a read burst in its middle and checks both edges of the suspend window. An enable that is not registered would freeze one beat too early, and a missing hold would drop or repeat beats. It also runs a read-to-write turnaround with the mask raised in advance, where a wrong read latency shows up as the output enable and the write strobe being high together.

// File: rtl/sdram_dio_pkg.sv
package sdram_dio_pkg;
  parameter int unsigned DQ_W = 16;

  typedef struct packed {
    logic            valid;
    logic            mask;
    logic [DQ_W-1:0] data;
  } rd_beat_t;
endpackage

// File: rtl/sdram_dio_suspend.sv
module sdram_dio_suspend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  output logic clk_en_o
);
  logic cke_q;

  // one-clock entry/exit latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  assign clk_en_o = cke_q;
endmodule

// File: rtl/sdram_dio_rdpipe.sv
module sdram_dio_rdpipe
  import sdram_dio_pkg::*;
#(
  parameter int unsigned LAT = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  rd_beat_t beat_i,
  output rd_beat_t beat_o
);
  rd_beat_t stg [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stg
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stg[i] <= '0;
        else if (en_i) stg[i] <= beat_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stg[i] <= '0;
        else if (en_i) stg[i] <= stg[i-1];
      end
    end
  end

  assign beat_o = stg[LAT-1];
endmodule

// File: rtl/sdram_dio_wrmask.sv
module sdram_dio_wrmask (
  input  logic en_i,
  input  logic dqm_i,
  input  logic wr_valid_i,
  output logic wr_en_o
);
  // zero-latency mask: no register in this path
  always_comb wr_en_o = wr_valid_i & ~dqm_i & en_i;
endmodule

// File: rtl/sdram_dio_ctrl.sv
module sdram_dio_ctrl
  import sdram_dio_pkg::*;
#(
  parameter int unsigned RD_LAT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cke_i,
  input  logic            dqm_i,
  input  logic            rd_valid_i,
  input  logic [DQ_W-1:0] rd_data_i,
  input  logic            wr_valid_i,
  output logic [DQ_W-1:0] rd_data_o,
  output logic            dq_oe_o,
  output logic            wr_en_o
);
  logic     clk_en;
  rd_beat_t beat_in, beat_out;

  sdram_dio_suspend u_susp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cke_i    (cke_i),
    .clk_en_o (clk_en)
  );

  always_comb begin
    beat_in.valid = rd_valid_i;
    beat_in.mask  = dqm_i;
    beat_in.data  = rd_data_i;
  end

  sdram_dio_rdpipe #(.LAT(RD_LAT)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en),
    .beat_i (beat_in),
    .beat_o (beat_out)
  );

  sdram_dio_wrmask u_wr (
    .en_i       (clk_en),
    .dqm_i      (dqm_i),
    .wr_valid_i (wr_valid_i),
    .wr_en_o    (wr_en_o)
  );

  assign rd_data_o = beat_out.data;
  assign dq_oe_o   = beat_out.valid & ~beat_out.mask;
endmodule

// File: rtl/sdram_dio_ctrl_chk.sv
module sdram_dio_ctrl_chk
  import sdram_dio_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cke_i,
  input logic            dqm_i,
  input logic            wr_valid_i,
  input logic [DQ_W-1:0] rd_data_o,
  input logic            dq_oe_o,
  input logic            wr_en_o
);
  logic cke_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_d <= 1'b1;
    else         cke_d <= cke_i;
  end

  p_mask_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_valid_i && !dqm_i));

  p_pass_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !dqm_i && cke_d) |-> wr_en_o);

  p_hold_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_d |=> $stable(rd_data_o));

  p_hold_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_d |=> $stable(dq_oe_o));

  p_no_write_susp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_d |-> !wr_en_o);
endmodule

bind sdram_dio_ctrl sdram_dio_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cke_i      (cke_i),
  .dqm_i      (dqm_i),
  .wr_valid_i (wr_valid_i),
  .rd_data_o  (rd_data_o),
  .dq_oe_o    (dq_oe_o),
  .wr_en_o    (wr_en_o)
);

// File: tb/sdram_dio_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_dio_ctrl_bench;
  localparam int DW = sdram_dio_pkg::DQ_W;

  typedef struct {
    logic          valid;
    logic          mask;
    logic [DW-1:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cke = 1'b1, dqm = 1'b0, rv = 1'b0, wv = 1'b0;
  logic [DW-1:0] rdat = '0;
  logic [DW-1:0] rd_data_o;
  logic dq_oe_o, wr_en_o;

  int checks = 0, errors = 0;
  exp_t q[$];
  exp_t cur;
  logic m_en = 1'b1, m_en_prev = 1'b1;
  logic armed = 1'b0, turn_chk = 1'b0;

  always #2 clk = ~clk;

  sdram_dio_ctrl u_sdram_dio_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .dqm_i(dqm),
    .rd_valid_i(rv), .rd_data_i(rdat), .wr_valid_i(wv),
    .rd_data_o(rd_data_o), .dq_oe_o(dq_oe_o), .wr_en_o(wr_en_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: apply one cycle of inputs, then update the scoreboard at the edge
  task automatic step(logic c, logic d, logic r, logic w, logic [DW-1:0] v);
    exp_t it;
    cke = c; dqm = d; rv = r; wv = w; rdat = v;
    @(posedge clk);
    m_en_prev = m_en;
    if (m_en) begin
      it.valid = r; it.mask = d; it.data = v;
      q.push_back(it);
      cur = q.pop_front();
    end
    m_en = c;
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (armed) begin
      string tag;
      if (!m_en_prev)              tag = "R6";
      else if (m_en != m_en_prev)  tag = "R5";
      else if (!cur.valid)         tag = "R8";
      else if (cur.mask)           tag = "R3";
      else                         tag = "R2";
      chk(tag, dq_oe_o, cur.valid & ~cur.mask);
      if (cur.valid && !cur.mask) chk(tag, rd_data_o, cur.data);
      chk(m_en ? "R4" : "R7", wr_en_o, wv & ~dqm & m_en);
      if (turn_chk) chk("R9", dq_oe_o & wr_en_o, 1'b0);
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_t idle;
    idle.valid = 1'b0; idle.mask = 1'b0; idle.data = '0;
    cur = idle;
    q.push_back(idle);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", dq_oe_o, 1'b0);
    chk("R1", wr_en_o, 1'b0);
    chk("R1", rd_data_o, '0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1", dq_oe_o, 1'b0);
    chk("R1", rd_data_o, '0);
    armed = 1'b1;

    // plain read burst then idle (R2, R8)
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0, DW'(16'hA0 + i));
    repeat (3) step(1, 0, 0, 0, '0);

    // masked beat inside a read burst (R3)
    step(1, 0, 1, 0, DW'(16'hB0));
    step(1, 1, 1, 0, DW'(16'hB1));
    step(1, 0, 1, 0, DW'(16'hB2));
    step(1, 1, 1, 0, DW'(16'hB3));
    repeat (3) step(1, 0, 0, 0, '0);

    // write strobes with zero-latency mask (R4)
    step(1, 0, 0, 1, '0);
    step(1, 1, 0, 1, '0);
    step(1, 0, 0, 1, '0);
    step(1, 1, 0, 0, '0);
    step(1, 0, 0, 0, '0);

    // read burst suspended in the middle (R5, R6), writes during suspend (R7)
    step(1, 0, 1, 0, DW'(16'hC0));
    step(1, 0, 1, 0, DW'(16'hC1));
    step(0, 0, 1, 0, DW'(16'hC2));
    step(0, 0, 1, 1, DW'(16'hEE));
    step(1, 0, 1, 1, DW'(16'hEF));
    step(1, 0, 1, 0, DW'(16'hC3));
    repeat (3) step(1, 0, 0, 0, '0);

    // suspend while idle, then write resumes on exit (R5, R7)
    step(0, 0, 0, 1, '0);
    step(1, 0, 0, 1, '0);
    step(1, 0, 0, 1, '0);
    step(1, 0, 0, 0, '0);

    // read interrupted by write with early mask (R9)
    turn_chk = 1'b1;
    step(1, 0, 1, 0, DW'(16'hD0));
    step(1, 0, 1, 0, DW'(16'hD1));
    step(1, 1, 1, 0, DW'(16'hD2));
    step(1, 1, 1, 0, DW'(16'hD3));
    step(1, 0, 0, 1, '0);
    step(1, 0, 0, 1, '0);
    step(1, 0, 0, 0, '0);
    turn_chk = 1'b0;
    repeat (2) step(1, 0, 0, 0, '0);

    armed = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule